// File: doc/BRIEF.md
# Program Status Word Update Unit

This unit holds the live processor status word and a saved copy of it for each privileged exception bank. It accepts move-to-status writes that carry a 4-bit field selector, picks which fields of the target word change, and applies the privilege rules of the current mode. The flags, interrupt masks, thumb bit and 5-bit mode go out as separate pins that the banked register file and the condition logic read. A one-cycle pulse tells the register file that the mode field has just changed.

A second write path serves exception entry. In a single cycle it loads a complete new live word and saves the previous live word into the saved slot of the bank that the new mode selects. The saved word of any mode can be read back combinationally. A mode that has no saved slot reads back the live word instead.

Status writes arrive on a valid/ready channel. `wr_ready` is low in any cycle where `exc_valid` is high, so exception entry always wins. A write is taken on a rising edge where both `wr_valid` and `wr_ready` are high, and its result is visible after that edge. The sender must hold its request until it sees ready. The exception path and the read path have no handshake.

Top module: `psr_write_ctrl`

## Requirements
- R1: After reset the live word is 32'h0000_00D3 (supervisor mode 5'h13, IRQ and FIQ masks set). Every saved word is zero and `mode_chg` is low.
- R2: In a user-bank mode (5'h10 or 5'h00), an accepted live write changes only bits 31:28, and only when selector bit 3 is set. All other bits keep their values.
- R3: In any other mode, an accepted live write whose selector is exactly 4'b1001 replaces the whole word.
- R4: In any other mode with a selector other than 4'b1001, selector bit 0 wins. If it is set, only bits 7:6 and 4:0 change. If it is clear and selector bit 3 is set, only bits 31:28 change. If both are clear, nothing changes. Bit 5 never changes this way.
- R5: A write with `wr_to_saved` high applies the R3/R4 selector rules to the saved word of the current bank and leaves the live word unchanged. The write is ignored when the current bank is user (5'h10, 5'h00), system (5'h1F) or any unlisted mode.
- R6: `rd_spsr` returns the saved word of the bank that `rd_mode` selects: FIQ 5'h11/5'h01, IRQ 5'h12/5'h02, supervisor 5'h13/5'h03, abort 5'h17, undefined 5'h1B. For any other mode it returns the live word.
- R7: While `prog32_en` is low, every live-word update is ANDed with 32'hF000_00C3. This keeps only the flags, the two interrupt masks and mode bits 1:0.
- R8: The output pins carry these live-word bits: N bit 31, Z bit 30, C bit 29, V bit 28, IRQ mask bit 7, FIQ mask bit 6, thumb bit 5, mode bits 4:0.
- R9: When `exc_valid` is high, the live word becomes `exc_word` (subject to R7). If the mode in `exc_word[4:0]` has a saved slot, that slot receives the previous live word.
- R10: `mode_chg` is high for exactly the one cycle in which a new mode value first shows on `mode`, and it is low otherwise.
- R11: `wr_ready` is the inverse of `exc_valid`. A request offered while `exc_valid` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog32_en | input | 1 | 32-bit program space enable; low narrows the live word |
| wr_valid | input | 1 | Status write request valid |
| wr_ready | output | 1 | Status write request accepted when high |
| wr_to_saved | input | 1 | 1 targets the current bank's saved word, 0 the live word |
| wr_mask | input | 4 | Field selector (instruction bits 19:16) |
| wr_data | input | 32 | Source operand of the write |
| exc_valid | input | 1 | Exception entry load |
| exc_word | input | 32 | New live word for exception entry |
| rd_mode | input | 5 | Mode whose saved word is read |
| rd_spsr | output | 32 | Saved word of rd_mode, or live word |
| cpsr | output | 32 | Live status word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_mask | output | 1 | IRQ disable |
| fiq_mask | output | 1 | FIQ disable |
| thumb | output | 1 | Thumb state bit |
| mode | output | 5 | Current mode to the register file |
| mode_chg | output | 1 | One-cycle pulse on a mode change |

## Verification
On every cycle the assertions check the following. A user-mode live write leaves bits 27:0 untouched. A saved-word write never moves the live word. Exception entry loads `exc_word` exactly. Narrowed updates leave the dropped bits at zero. `mode_chg` tracks mode transitions in both directions. The field-priority ordering, the exact merged values, the choice of saved slot, the read fallback to the live word and the saved-word state after an ignored write all depend on particular values and sequences. Only the bench's directed scenarios against its reference model show those.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 5;
  localparam int SEL_W  = 4;
  localparam int BANK_W = 3;

  localparam logic [WORD_W-1:0] FLAG_FIELD  = 32'hF000_0000;
  localparam logic [WORD_W-1:0] CTRL_FIELD  = 32'h0000_00DF;
  localparam logic [WORD_W-1:0] NARROW_KEEP = 32'hF000_00C3;
  localparam logic [WORD_W-1:0] RESET_WORD  = 32'h0000_00D3;
  localparam logic [SEL_W-1:0]  SEL_WHOLE   = 4'b1001;

  localparam int BIT_N = 31;
  localparam int BIT_Z = 30;
  localparam int BIT_C = 29;
  localparam int BIT_V = 28;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  typedef enum logic [BANK_W-1:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_NONE
  } bank_e;

  localparam int SAVED_SLOTS = 5;

  typedef enum logic [1:0] {UPD_NONE, UPD_FLAGS, UPD_CTRL, UPD_FULL} upd_e;

  function automatic logic [WORD_W-1:0] psr_merge(input logic [WORD_W-1:0] old_w,
                                                  input logic [WORD_W-1:0] new_w,
                                                  input upd_e u);
    logic [WORD_W-1:0] r;
    case (u)
      UPD_FULL:  r = new_w;
      UPD_CTRL:  r = (old_w & ~CTRL_FIELD) | (new_w & CTRL_FIELD);
      UPD_FLAGS: r = (old_w & ~FLAG_FIELD) | (new_w & FLAG_FIELD);
      default:   r = old_w;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/psr_bank_map.sv
module psr_bank_map
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_in,
  output bank_e             bank,
  output logic              has_saved
);
  always_comb begin
    case (mode_in)
      5'h10, 5'h00: bank = BK_USR;
      5'h11, 5'h01: bank = BK_FIQ;
      5'h12, 5'h02: bank = BK_IRQ;
      5'h13, 5'h03: bank = BK_SVC;
      5'h17:        bank = BK_ABT;
      5'h1B:        bank = BK_UND;
      5'h1F:        bank = BK_SYS;
      default:      bank = BK_NONE;
    endcase
  end

  assign has_saved = (bank != BK_USR) && (bank != BK_SYS) && (bank != BK_NONE);
endmodule

// File: rtl/psr_mask_decode.sv
module psr_mask_decode
  import psr_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             privileged,
  output upd_e             upd
);
  always_comb begin
    if (privileged && sel == SEL_WHOLE)  upd = UPD_FULL;
    else if (privileged && sel[0])       upd = UPD_CTRL;
    else if (sel[SEL_W-1])               upd = UPD_FLAGS;
    else                                 upd = UPD_NONE;
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int SLOTS = SAVED_SLOTS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  bank_e        wr_bank,
  input  logic [W-1:0] wr_word,
  input  bank_e        rd_a_bank,
  output logic [W-1:0] rd_a_word,
  input  bank_e        rd_b_bank,
  output logic [W-1:0] rd_b_word
);
  logic [W-1:0] slot_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam bank_e OWNER = bank_e'(BANK_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           slot_q[i] <= '0;
      else if (wr_en && wr_bank == OWNER)   slot_q[i] <= wr_word;
    end
  end

  always_comb begin
    rd_a_word = '0;
    rd_b_word = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (rd_a_bank == bank_e'(BANK_W'(k + 1))) rd_a_word = slot_q[k];
      if (rd_b_bank == bank_e'(BANK_W'(k + 1))) rd_b_word = slot_q[k];
    end
  end
endmodule

// File: rtl/psr_write_ctrl.sv
module psr_write_ctrl
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog32_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_to_saved,
  input  logic [SEL_W-1:0]  wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              exc_valid,
  input  logic [WORD_W-1:0] exc_word,
  input  logic [MODE_W-1:0] rd_mode,
  output logic [WORD_W-1:0] rd_spsr,
  output logic [WORD_W-1:0] cpsr,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              irq_mask,
  output logic              fiq_mask,
  output logic              thumb,
  output logic [MODE_W-1:0] mode,
  output logic              mode_chg
);
  logic [WORD_W-1:0] live_q, live_raw, live_d;
  logic              live_we;
  logic              chg_q;

  bank_e cur_bank, rd_bank, exc_bank;
  logic  cur_has, rd_has, exc_has;
  upd_e  upd_live, upd_saved;

  logic [WORD_W-1:0] cur_saved_word, rd_saved_word, saved_wr_word;
  logic              saved_we;
  bank_e             saved_wr_bank;

  logic wr_take;

  psr_bank_map u_map_cur (.mode_in(live_q[MODE_W-1:0]), .bank(cur_bank), .has_saved(cur_has));
  psr_bank_map u_map_rd  (.mode_in(rd_mode),             .bank(rd_bank),  .has_saved(rd_has));
  psr_bank_map u_map_exc (.mode_in(exc_word[MODE_W-1:0]), .bank(exc_bank), .has_saved(exc_has));

  psr_mask_decode u_dec_live  (.sel(wr_mask), .privileged(cur_bank != BK_USR), .upd(upd_live));
  psr_mask_decode u_dec_saved (.sel(wr_mask), .privileged(1'b1),               .upd(upd_saved));

  assign wr_ready = !exc_valid;
  assign wr_take  = wr_valid && wr_ready;

  always_comb begin
    live_we  = 1'b0;
    live_raw = live_q;
    if (exc_valid) begin
      live_we  = 1'b1;
      live_raw = exc_word;
    end else if (wr_take && !wr_to_saved) begin
      live_we  = 1'b1;
      live_raw = psr_merge(live_q, wr_data, upd_live);
    end
    live_d = prog32_en ? live_raw : (live_raw & NARROW_KEEP);
  end

  always_comb begin
    saved_we      = 1'b0;
    saved_wr_bank = BK_NONE;
    saved_wr_word = live_q;
    if (exc_valid) begin
      saved_we      = exc_has;
      saved_wr_bank = exc_bank;
      saved_wr_word = live_q;
    end else if (wr_take && wr_to_saved) begin
      saved_we      = cur_has;
      saved_wr_bank = cur_bank;
      saved_wr_word = psr_merge(cur_saved_word, wr_data, upd_saved);
    end
  end

  psr_saved_bank u_saved (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (saved_we),
    .wr_bank   (saved_wr_bank),
    .wr_word   (saved_wr_word),
    .rd_a_bank (cur_bank),
    .rd_a_word (cur_saved_word),
    .rd_b_bank (rd_bank),
    .rd_b_word (rd_saved_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= RESET_WORD;
      chg_q  <= 1'b0;
    end else begin
      if (live_we) live_q <= live_d;
      chg_q <= live_we && (live_d[MODE_W-1:0] != live_q[MODE_W-1:0]);
    end
  end

  assign rd_spsr  = rd_has ? rd_saved_word : live_q;
  assign cpsr     = live_q;
  assign flag_n   = live_q[BIT_N];
  assign flag_z   = live_q[BIT_Z];
  assign flag_c   = live_q[BIT_C];
  assign flag_v   = live_q[BIT_V];
  assign irq_mask = live_q[BIT_I];
  assign fiq_mask = live_q[BIT_F];
  assign thumb    = live_q[BIT_T];
  assign mode     = live_q[MODE_W-1:0];
  assign mode_chg = chg_q;
endmodule

// File: rtl/psr_write_ctrl_chk.sv
module psr_write_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        prog32_en,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        wr_to_saved,
  input logic [3:0]  wr_mask,
  input logic [31:0] wr_data,
  input logic        exc_valid,
  input logic [31:0] exc_word,
  input logic [4:0]  rd_mode,
  input logic [31:0] rd_spsr,
  input logic [31:0] cpsr,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_c,
  input logic        flag_v,
  input logic        irq_mask,
  input logic        fiq_mask,
  input logic        thumb,
  input logic [4:0]  mode,
  input logic        mode_chg
);
  logic in_user;
  assign in_user = (cpsr[4:0] == 5'h10) || (cpsr[4:0] == 5'h00);

  assert_user_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_user && wr_valid && wr_ready && !wr_to_saved) |=> (cpsr[27:0] == $past(cpsr[27:0])));

  assert_saved_keeps_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_to_saved) |=> $stable(cpsr));

  assert_narrow_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog32_en && (exc_valid || (wr_valid && wr_ready && !wr_to_saved)))
      |=> ((cpsr & 32'h0FFF_FF3C) == 32'h0));

  assert_exception_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && prog32_en) |=> (cpsr == $past(exc_word)));

  assert_pulse_follows_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> (mode != $past(mode)));

  assert_mode_raises_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> mode_chg);

  assert_ready_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !wr_ready);
endmodule

bind psr_write_ctrl psr_write_ctrl_chk u_chk (.*);

// File: tb/psr_write_ctrl_test.sv
module psr_write_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog32_en = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_to_saved = 1'b0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic        exc_valid = 1'b0;
  logic [31:0] exc_word = '0;
  logic [4:0]  rd_mode = 5'h13;
  logic [31:0] rd_spsr, cpsr;
  logic        flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask, thumb, mode_chg;
  logic [4:0]  mode;

  always #2 clk = ~clk;

  psr_write_ctrl uut (.*);

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] mdl_cpsr = 32'h0000_00D3;
  logic [31:0] mdl_saved [0:7];

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h00: return 0;
      5'h11, 5'h01: return 1;
      5'h12, 5'h02: return 2;
      5'h13, 5'h03: return 3;
      5'h17:        return 4;
      5'h1B:        return 5;
      5'h1F:        return 6;
      default:      return 7;
    endcase
  endfunction

  function automatic bit has_slot(input int b);
    return (b >= 1 && b <= 5);
  endfunction

  function automatic logic [31:0] apply_sel(input logic [31:0] o, input logic [31:0] d,
                                            input logic [3:0] s, input bit priv);
    if (priv && s == 4'b1001) return d;
    if (priv && s[0])         return (o & 32'hFFFF_FF20) | (d & 32'h0000_00DF);
    if (s[3])                 return (o & 32'h0FFF_FFFF) | (d & 32'hF000_0000);
    return o;
  endfunction

  function automatic logic [31:0] narrow(input logic [31:0] v);
    return prog32_en ? v : (v & 32'hF000_00C3);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [12:0] pins, epins;
      it = sbq.pop_front();
      case (it.kind)
        0: begin
          check(cpsr === it.exp, it.tag, cpsr, it.exp);
          pins  = {flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask, thumb, mode, 1'b0};
          epins = {it.exp[31:28], it.exp[7], it.exp[6], it.exp[5], it.exp[4:0], 1'b0};
          check(pins === epins, "R8 pins", {19'd0, pins}, {19'd0, epins});
        end
        1: check(rd_spsr === it.exp, it.tag, rd_spsr, it.exp);
        2: check(mode_chg === it.exp[0], it.tag, {31'd0, mode_chg}, it.exp);
        default: ;
      endcase
    end
  end

  task automatic op_write(input bit saved, input logic [3:0] s, input logic [31:0] d, input string tag);
    logic [31:0] old;
    int b;
    @(negedge clk);
    wr_valid = 1'b1; wr_to_saved = saved; wr_mask = s; wr_data = d;
    #1 check(wr_ready === 1'b1, "R11 ready", {31'd0, wr_ready}, 32'd1);
    old = mdl_cpsr;
    b = bank_of(old[4:0]);
    if (!saved) mdl_cpsr = narrow(apply_sel(old, d, s, b != 0));
    else if (has_slot(b)) mdl_saved[b] = apply_sel(mdl_saved[b], d, s, 1'b1);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    push(0, mdl_cpsr, tag);
    push(2, {31'd0, old[4:0] != mdl_cpsr[4:0]}, "R10 pulse");
  endtask

  task automatic op_exc(input logic [31:0] w, input string tag);
    logic [31:0] old;
    int b;
    @(negedge clk);
    exc_valid = 1'b1; exc_word = w;
    wr_valid = 1'b1; wr_to_saved = 1'b0; wr_mask = 4'b1001; wr_data = 32'h0F0F_0F1B;
    #1 check(wr_ready === 1'b0, "R11 blocked", {31'd0, wr_ready}, 32'd0);
    old = mdl_cpsr;
    b = bank_of(w[4:0]);
    if (has_slot(b)) mdl_saved[b] = old;
    mdl_cpsr = narrow(w);
    @(posedge clk); #1;
    exc_valid = 1'b0; wr_valid = 1'b0;
    push(0, mdl_cpsr, tag);
    push(2, {31'd0, old[4:0] != mdl_cpsr[4:0]}, "R10 pulse");
  endtask

  task automatic rd_expect(input logic [4:0] m, input string tag);
    int b;
    @(posedge clk); #1;
    rd_mode = m;
    b = bank_of(m);
    push(1, has_slot(b) ? mdl_saved[b] : mdl_cpsr, tag);
    push(2, 32'd0, "R10 width");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl_saved[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    push(0, 32'h0000_00D3, "R1 reset word");
    push(2, 32'd0, "R1 no pulse");
    push(1, 32'd0, "R1 saved zero");

    op_write(1'b0, 4'b1001, 32'h5000_00F2, "R3 whole");
    op_write(1'b0, 4'b0001, 32'hF000_0033, "R4 control");
    op_write(1'b0, 4'b1000, 32'hA000_1234, "R4 flags");
    op_write(1'b0, 4'b1111, 32'h0000_00D7, "R4 priority");
    op_write(1'b0, 4'b0110, 32'hFFFF_FFFF, "R4 none");
    op_write(1'b1, 4'b1001, 32'h1234_5678, "R5 live kept");
    rd_expect(5'h17, "R5 saved abort");
    rd_expect(5'h10, "R6 user reads live");
    rd_expect(5'h1F, "R6 system reads live");
    rd_expect(5'h05, "R6 unlisted reads live");
    op_write(1'b1, 4'b0001, 32'h0000_00FF, "R5 live kept ctrl");
    rd_expect(5'h17, "R5 saved control merge");

    op_write(1'b0, 4'b1001, 32'h0000_001F, "R3 to system");
    op_write(1'b1, 4'b1001, 32'hDEAD_BEEF, "R5 system ignored live");
    rd_expect(5'h11, "R5 system ignored fiq");
    rd_expect(5'h12, "R5 system ignored irq");
    rd_expect(5'h13, "R5 system ignored svc");
    rd_expect(5'h17, "R5 system ignored abt");
    rd_expect(5'h1B, "R5 system ignored und");

    op_write(1'b0, 4'b1001, 32'h0000_0010, "R3 to user");
    op_write(1'b0, 4'b1001, 32'hFFFF_FFFF, "R2 flags only");
    op_write(1'b0, 4'b0111, 32'h0000_0000, "R2 no bit 19");
    op_write(1'b1, 4'b1001, 32'h0000_0001, "R5 user ignored live");
    rd_expect(5'h13, "R5 user ignored svc");
    rd_expect(5'h17, "R5 user ignored abt");

    op_exc(32'h0000_00D1, "R9 enter fiq");
    rd_expect(5'h11, "R9 fiq saved old");
    rd_expect(5'h01, "R6 narrow fiq alias");

    prog32_en = 1'b0;
    op_write(1'b0, 4'b1001, 32'hFFFF_FFFF, "R7 narrow whole");
    op_write(1'b0, 4'b0001, 32'h0000_0012, "R7 narrow control");
    rd_expect(5'h02, "R6 irq alias");
    op_exc(32'h0000_00DB, "R7 R9 narrow entry");
    rd_expect(5'h1B, "R9 und saved old");
    prog32_en = 1'b1;
    op_write(1'b0, 4'b1001, 32'h8000_0013, "R3 back to svc");

    repeat (3) @(posedge clk);
    #1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule